// File: doc/BRIEF.md
# Hybrid DC Breaker Switching Sequencer

This block orders the switching steps of a hybrid DC breaker that has a low-loss load branch and a main branch of series semiconductor cells. The load branch holds a commutation switch and a fast disconnector. A residual breaker in series clears what little current is left. The block takes two active-low commands from a protection relay. The first is an inner-zone trip that forces a full open. The second asks the breaker to limit current for a fault outside its zone. Local overcurrent and bus-undervoltage flags can also request limiting. The analog comparators and the cell current regulator are outside this block. The block sees only their flags.

Both a trip and a limiting request run the same opening sequence: commutation switch, disconnector, then the main branch. A trip blocks all cells at once, which is the same as limiting towards zero current. A limiting request instead hands the main branch to the cell regulator (`lim_en`). The limiting episode ends in one of two ways:
- It opens fully on a trip, on cell over-energy, or when the dwell counter expires.
- It re-closes through the disconnector and then the commutation switch, either once every cell has returned to bypass or once no limiting request remains.

Each wait for a status flag has a timeout. An expired timeout drops the block into a latched fault-open state.

Top module: `hbrk_seq`

## Requirements
- R1: Out of reset the breaker is closed: `lcs_en`=1, `disc_en`=1, `st_closed`=1, and `lim_en`, `mb_block`, `rcb_open`, `st_open`, `flt`, `open_pulse`, `close_pulse` are all 0.
- R2: From closed, `trip_n`=0 runs a full open that ends with `rcb_open`=1, `st_open`=1 and one `open_pulse`, with `lim_en` never asserted.
- R3: Opening goes in this order, each step waiting for its flag:
  - `lcs_en` falls, then `iload_low`;
  - `disc_en` falls, then `disc_open`;
  - main-branch action, then `iline_low`;
  - `rcb_open` rises.
- R4: From closed, limiting is entered, after the load-branch steps, on `limit_n`=0, `oc_flag`=1 or `uv_flag`=1. During limiting `lim_en`=1 and `disc_en`=0.
- R5: When `trip_n`=0 and a limiting request arrive together, the trip wins: the breaker opens and `lim_en` stays 0.
- R6: While limiting, `cell_over_e`=1 or `trip_n`=0 ends limiting with a full open (one `open_pulse`).
- R7: `lim_en` stays high for at most `dwell_limit`+1 consecutive cycles. If no other exit occurs, it is high for exactly that many cycles before a full open.
- R8: While limiting, `cells_all_closed`=1, or all of `limit_n`=1, `oc_flag`=0 and `uv_flag`=0, re-closes the breaker:
  - `disc_en` rises first;
  - after `disc_closed`, `lcs_en` rises with `st_closed`=1 and one `close_pulse`.
- R9: If an open condition and a close condition hold in the same limiting cycle, the breaker opens.
- R10: If a waited-for flag does not arrive within `WAIT_MAX` cycles, the block enters a latched fault state. In that state `flt`=1, `st_open`=1, `rcb_open`=1, `mb_block`=1, `lcs_en`=0 and `disc_en`=0, no pulse is issued, and only reset leaves it.
- R11: `open_pulse` and `close_pulse` are each one cycle wide and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_n | input | 1 | Inner-zone trip command, active low |
| limit_n | input | 1 | Outer-zone limiting request, active low |
| oc_flag | input | 1 | Local overcurrent indication |
| uv_flag | input | 1 | Local bus undervoltage indication |
| iload_low | input | 1 | Load-branch current below residual threshold |
| iline_low | input | 1 | Line current below residual threshold |
| disc_open | input | 1 | Disconnector reports fully open |
| disc_closed | input | 1 | Disconnector reports fully closed |
| cell_over_e | input | 1 | Some cell's absorbed energy exceeds its trip level |
| cells_all_closed | input | 1 | All main-branch cells are bypassed |
| dwell_limit | input | CW | Main-branch dwell limit in cycles |
| lcs_en | output | 1 | Commutation switch conducting |
| disc_en | output | 1 | Disconnector commanded closed |
| lim_en | output | 1 | Main branch in current-limiting mode |
| mb_block | output | 1 | All main-branch cells blocking |
| rcb_open | output | 1 | Residual breaker opened |
| st_open | output | 1 | Final status open |
| st_closed | output | 1 | Final status closed |
| open_pulse | output | 1 | One-cycle report of an open outcome |
| close_pulse | output | 1 | One-cycle report of a re-close outcome |
| flt | output | 1 | Latched sequencing fault |

## Verification
The checker assumes the following about the inputs:
- the disconnector never reports open and closed at once;
- `dwell_limit` does not change while limiting is in progress;
- each current flag reflects the branch that the block has just switched.

The bench holds to these by driving the status flags from a small plant model. That model delays each command by a fixed number of cycles. A separate knob stalls the disconnector, so the timeout path can be reached without making the flags contradict each other. `dwell_limit` is written only while the breaker sits closed.

// File: rtl/hbrk_seq.sv
module hbrk_seq #(
  parameter int CW       = 16,
  parameter int WAIT_MAX = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip_n,
  input  logic          limit_n,
  input  logic          oc_flag,
  input  logic          uv_flag,
  input  logic          iload_low,
  input  logic          iline_low,
  input  logic          disc_open,
  input  logic          disc_closed,
  input  logic          cell_over_e,
  input  logic          cells_all_closed,
  input  logic [CW-1:0] dwell_limit,
  output logic          lcs_en,
  output logic          disc_en,
  output logic          lim_en,
  output logic          mb_block,
  output logic          rcb_open,
  output logic          st_open,
  output logic          st_closed,
  output logic          open_pulse,
  output logic          close_pulse,
  output logic          flt
);

  localparam logic [CW-1:0] TMO_AT = CW'(WAIT_MAX - 1);

  typedef enum logic [3:0] {
    S_CLOSED, S_LCS, S_DISC, S_MB, S_RES, S_OPEN, S_RDISC, S_FLT
  } st_t;

  st_t           state, nxt;
  logic          full, full_d;
  logic [CW-1:0] cnt;

  wire req = !limit_n || oc_flag || uv_flag;
  wire tmo = (cnt == TMO_AT);

  always_comb begin
    nxt    = state;
    full_d = full;
    unique case (state)
      S_CLOSED: begin
        if (!trip_n) begin
          nxt = S_LCS; full_d = 1'b1;
        end else if (req) begin
          nxt = S_LCS; full_d = 1'b0;
        end
      end
      S_LCS: begin
        if (!trip_n) full_d = 1'b1;
        if (iload_low) nxt = S_DISC;
        else if (tmo)  nxt = S_FLT;
      end
      S_DISC: begin
        if (!trip_n) full_d = 1'b1;
        if (disc_open) nxt = S_MB;
        else if (tmo)  nxt = S_FLT;
      end
      S_MB: begin
        if (full) nxt = S_RES;
        else if (!trip_n || cell_over_e || cnt == dwell_limit) begin
          nxt = S_RES; full_d = 1'b1;
        end else if (cells_all_closed || !req) nxt = S_RDISC;
      end
      S_RES: begin
        if (iline_low) nxt = S_OPEN;
        else if (tmo)  nxt = S_FLT;
      end
      S_RDISC: begin
        if (disc_closed) nxt = S_CLOSED;
        else if (tmo)    nxt = S_FLT;
      end
      default: nxt = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_CLOSED;
      full        <= 1'b0;
      cnt         <= '0;
      open_pulse  <= 1'b0;
      close_pulse <= 1'b0;
    end else begin
      state       <= nxt;
      full        <= full_d;
      open_pulse  <= (nxt == S_OPEN) && (state != S_OPEN);
      close_pulse <= (nxt == S_CLOSED) && (state == S_RDISC);
      if (nxt != state)                            cnt <= '0;
      else if (state != S_OPEN && state != S_FLT)  cnt <= cnt + 1'b1;
    end
  end

  assign lcs_en    = (state == S_CLOSED);
  assign disc_en   = (state == S_CLOSED) || (state == S_LCS) || (state == S_RDISC);
  assign lim_en    = (state == S_MB) && !full;
  assign mb_block  = ((state == S_MB) && full) || (state == S_RES) || rcb_open;
  assign rcb_open  = (state == S_OPEN) || (state == S_FLT);
  assign st_open   = rcb_open;
  assign st_closed = (state == S_CLOSED);
  assign flt       = (state == S_FLT);

endmodule

// File: rtl/hbrk_seq_chk.sv
module hbrk_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iline_low,
  input logic          disc_closed,
  input logic [CW-1:0] dwell_limit,
  input logic          lcs_en,
  input logic          disc_en,
  input logic          lim_en,
  input logic          mb_block,
  input logic          rcb_open,
  input logic          open_pulse,
  input logic          close_pulse,
  input logic          flt
);

  logic [CW:0] lim_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_run <= '0;
    else if (lim_en) lim_run <= lim_run + 1'b1;
    else             lim_run <= '0;
  end

  // R3
  disc_after_lcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disc_en) |-> !lcs_en);

  // R3
  rcb_after_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rcb_open) |-> ($past(iline_low) || flt));

  // R4
  lim_disc_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lim_en |-> (!disc_en && !mb_block && !lcs_en));

  // R7
  dwell_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lim_en |-> (lim_run <= {1'b0, dwell_limit}));

  // R8
  lcs_after_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcs_en) |-> ($past(disc_closed) && disc_en));

  // R10
  flt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt |=> (flt && rcb_open && !lcs_en && !disc_en));

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({open_pulse, close_pulse}));

  // R11
  open_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_pulse |=> !open_pulse);

endmodule

bind hbrk_seq hbrk_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iline_low(iline_low), .disc_closed(disc_closed),
  .dwell_limit(dwell_limit), .lcs_en(lcs_en), .disc_en(disc_en),
  .lim_en(lim_en), .mb_block(mb_block), .rcb_open(rcb_open),
  .open_pulse(open_pulse), .close_pulse(close_pulse), .flt(flt)
);

// File: tb/tb_hbrk_seq.sv
module tb_hbrk_seq;
  localparam int CW = 16;
  localparam int WAIT_MAX = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip_n = 1'b1, limit_n = 1'b1, oc_flag = 1'b0, uv_flag = 1'b0;
  logic cell_over_e = 1'b0, cells_all_closed = 1'b0;
  logic disc_stuck = 1'b0;
  logic [CW-1:0] dwell_limit = 16'd200;
  logic iload_low, iline_low, disc_open, disc_closed;
  logic lcs_en, disc_en, lim_en, mb_block, rcb_open, st_open, st_closed;
  logic open_pulse, close_pulse, flt;

  always #2 clk = ~clk;

  hbrk_seq #(.CW(CW), .WAIT_MAX(WAIT_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .limit_n(limit_n),
    .oc_flag(oc_flag), .uv_flag(uv_flag), .iload_low(iload_low),
    .iline_low(iline_low), .disc_open(disc_open), .disc_closed(disc_closed),
    .cell_over_e(cell_over_e), .cells_all_closed(cells_all_closed),
    .dwell_limit(dwell_limit), .lcs_en(lcs_en), .disc_en(disc_en),
    .lim_en(lim_en), .mb_block(mb_block), .rcb_open(rcb_open),
    .st_open(st_open), .st_closed(st_closed), .open_pulse(open_pulse),
    .close_pulse(close_pulse), .flt(flt)
  );

  // plant model: delayed responses to the breaker commands
  logic [1:0] lcs_sh, mb_sh;
  logic [2:0] disc_sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcs_sh <= 2'b11; disc_sh <= 3'b111; mb_sh <= 2'b00;
    end else begin
      lcs_sh  <= {lcs_sh[0], lcs_en};
      disc_sh <= {disc_sh[1:0], disc_en};
      mb_sh   <= {mb_sh[0], mb_block};
    end
  end
  assign iload_low   = !lcs_sh[1];
  assign disc_open   = !disc_sh[2] && !disc_stuck;
  assign disc_closed = disc_sh[2];
  assign iline_low   = mb_sh[1];

  int checks = 0, fails = 0;
  int exp_q[$];
  int lim_cnt = 0, lim_run = 0, lim_max = 0;
  bit flt_q = 1'b0, done = 1'b0;

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic expect_outcome(int k);  // 0 open, 1 closed, 2 fault
    exp_q.push_back(k);
  endtask

  task automatic pop_cmp(int k);
    int e;
    if (exp_q.size() == 0) check("R11 unexpected outcome", k, -1);
    else begin
      e = exp_q.pop_front();
      check("R2/R6/R8/R10 outcome", k, e);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (open_pulse)  pop_cmp(0);
      if (close_pulse) pop_cmp(1);
      if (flt && !flt_q) pop_cmp(2);
      if (open_pulse && close_pulse) check("R11 pulses together", 1, 0);
      if (lim_en) begin
        lim_cnt++; lim_run++;
        if (lim_run > lim_max) lim_max = lim_run;
      end else lim_run = 0;
    end
    flt_q = flt;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    trip_n = 1'b1; limit_n = 1'b1; oc_flag = 1'b0; uv_flag = 1'b0;
    cell_over_e = 1'b0; cells_all_closed = 1'b0; disc_stuck = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lim_cnt = 0; lim_run = 0; lim_max = 0;
    @(negedge clk);
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    check({req, " outcome pending"}, exp_q.size(), 0);
    exp_q.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_lim();
    for (int i = 0; i < 200 && !lim_en; i++) @(negedge clk);
    check("R4 limiting entered", lim_en, 1);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check("R1 lcs_en", lcs_en, 1);
    check("R1 disc_en", disc_en, 1);
    check("R1 st_closed", st_closed, 1);
    check("R1 opens/flags", {lim_en, mb_block, rcb_open, st_open, flt, open_pulse, close_pulse}, 0);

    // R2 R3 trip from closed
    expect_outcome(0);
    trip_n = 1'b0;
    drain("R2");
    check("R2 st_open", st_open, 1);
    check("R3 rcb_open", rcb_open, 1);
    check("R3 lcs/disc off", {lcs_en, disc_en}, 0);
    check("R2 no limiting", lim_cnt, 0);

    // R4 R8 outer request then released
    do_reset();
    expect_outcome(1);
    limit_n = 1'b0;
    wait_lim();
    check("R4 disc_en low in limiting", disc_en, 0);
    repeat (3) @(negedge clk);
    limit_n = 1'b1;
    drain("R8");
    check("R8 st_closed", st_closed, 1);
    check("R8 lcs_en", lcs_en, 1);

    // R4 R8 overcurrent, cells return to bypass
    do_reset();
    expect_outcome(1);
    oc_flag = 1'b1;
    wait_lim();
    oc_flag = 1'b0; cells_all_closed = 1'b1;
    drain("R8");
    check("R8 closed after bypass", st_closed, 1);

    // R4 R6 undervoltage, cell energy trip
    do_reset();
    expect_outcome(0);
    uv_flag = 1'b1;
    wait_lim();
    cell_over_e = 1'b1;
    drain("R6");
    check("R6 open after energy", st_open, 1);

    // R6 trip during limiting
    do_reset();
    expect_outcome(0);
    limit_n = 1'b0;
    wait_lim();
    trip_n = 1'b0;
    drain("R6");
    check("R6 open after trip", rcb_open, 1);

    // R7 dwell expiry
    dwell_limit = 16'd5;
    do_reset();
    expect_outcome(0);
    limit_n = 1'b0;
    drain("R7");
    check("R7 limiting cycles", lim_max, 6);
    check("R7 open after dwell", st_open, 1);
    dwell_limit = 16'd200;

    // R5 trip and request together
    do_reset();
    expect_outcome(0);
    trip_n = 1'b0; limit_n = 1'b0; oc_flag = 1'b1;
    drain("R5");
    check("R5 no limiting", lim_cnt, 0);
    check("R5 open", st_open, 1);

    // R9 open and close conditions together
    do_reset();
    expect_outcome(0);
    limit_n = 1'b0;
    wait_lim();
    cell_over_e = 1'b1; cells_all_closed = 1'b1;
    drain("R9");
    check("R9 open wins", st_open, 1);
    check("R9 not closed", st_closed, 0);

    // R10 disconnector stall
    do_reset();
    expect_outcome(2);
    disc_stuck = 1'b1;
    trip_n = 1'b0;
    drain("R10");
    check("R10 flt", flt, 1);
    check("R10 outputs", {st_open, rcb_open, mb_block, lcs_en, disc_en}, 5'b11100);
    trip_n = 1'b1; disc_stuck = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 latched", flt, 1);

    do_reset();
    check("R10 reset clears", {flt, st_closed}, 2'b01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule